// File: doc/BRIEF.md
# Half-Duplex Channel Access and Transmit Key Sequencer

This block decides when a packet radio transmitter may key up on a shared half-duplex channel, and tells the downstream frame encoder what to send on each byte opportunity once it has keyed up. On a periodic access tick it runs a p-persistent slotted contention scheme. A busy channel restarts the slot wait. On a clear channel the slot counter counts down, and a random byte is compared with the persistence setting only when the counter expires. In full-duplex operation the block keys up at once.

Once keyed, it commands a preamble of flag bytes, then frame data for as long as the encoder has a frame available, then a tail of flag bytes. The preamble and tail lengths are derived from the configured bit rate. During the tail, a newly available frame sends the block back to data. It returns to idle only when the transmitter's key feedback falls. A separate calibration mode commands a run of zero bytes, sized from a duration in seconds, whenever no frame transmission is in progress. The block also counts key-ups.

Top module: `ptt_seq`

## Requirements
- R1: After reset the block is idle: `key_o` is 0, `cmd_o` is 0 (none) and `keyups_o` is 0.
- R2: In half duplex, an access tick with a frame available and carrier present (`dcd_i`=1) does not key up and reloads the slot counter with the slot time.
- R3: In half duplex with the channel clear, each access tick decrements the slot counter. Only the tick that finds the counter at 1 or below reloads it and makes the persistence test.
- R4: That persistence test keys up only when `rnd_i` is less than or equal to the persistence setting. Otherwise the block waits a full slot time again.
- R5: In full duplex, any access tick with a frame available keys up at once, regardless of carrier, slot counter or random byte.
- R6: A key-up loads a preamble of floor(tx_delay × bitrate / 800) flag bytes (`cmd_o`=1), one per `byte_req_i`. A preamble length of 0 moves to data on the first byte request without sending anything.
- R7: In data, each byte request with `frame_avail_i`=1 commands a data byte (`cmd_o`=2). The first byte request without a frame moves to tail without a command and loads floor(tx_tail × bitrate / 800) tail flags. `cmd_o` is never nonzero without `byte_req_i`.
- R8: In tail, a byte request with a frame available returns to data without a command. The block returns to idle (`key_o`=0) only when `ptt_fb_i` is 0.
- R9: A `cal_start_i` pulse loads floor(seconds × bitrate / 8) zero bytes (`cmd_o`=3). These are sent one per byte request, only in idle or after the tail flags are used up. While any remain, the block does not key up.
- R10: `keyups_o` increments by one on every transition from idle to key-up.
- R11: A configuration write (`cfg_wr_i`) forces the slot counter to 1, so the next clear-channel tick makes the persistence test.
- R12: The configuration resets to tx_delay 20, tx_tail 2, persistence 40, half duplex, with slot time and bit rate set by parameters (defaults 10 and 9600).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Channel access tick |
| byte_req_i | input | 1 | Encoder can accept one byte this cycle |
| dcd_i | input | 1 | Carrier present on channel |
| frame_avail_i | input | 1 | Encoder holds frame bytes to send |
| ptt_fb_i | input | 1 | Transmitter key feedback |
| rnd_i | input | 8 | Random byte for persistence test |
| cfg_wr_i | input | 1 | Load all configuration inputs |
| cfg_txd_i | input | 8 | Preamble length, 10 ms units |
| cfg_tail_i | input | 8 | Tail length, 10 ms units |
| cfg_slot_i | input | 8 | Slot time in access ticks |
| cfg_persist_i | input | 8 | Persistence threshold |
| cfg_full_i | input | 1 | Full-duplex enable |
| cfg_bitrate_i | input | BR_W | Bit rate in bit/s |
| cal_start_i | input | 1 | Start calibration run |
| cal_secs_i | input | SEC_W | Calibration length in seconds |
| cmd_o | output | 2 | Byte command: 0 none, 1 flag, 2 data, 3 zero |
| key_o | output | 1 | Transmitter keyed (not idle) |
| keyups_o | output | KEYUP_W | Key-up count |

## Verification
The bench builds the block with `DEF_SLOT`=3 and `DEF_BITRATE`=1200. With these values the default preamble is 30 flags, the default tail is 3 flags and one second of calibration is 150 zeros. Whole slot countdowns, carrier reloads and persistence expiries then fit in a few ticks, and each preamble, tail and calibration run can be counted byte by byte. Reconfiguring the bit rate to 1000 gives a 25-flag preamble. A tx_delay of 7 at 1200 bit/s gives a preamble that truncates from 10.5 to 10, which checks the rounding. A tx_delay of 0 gives the empty preamble.

// File: rtl/ptt_seq_pkg.sv
package ptt_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_KEYUP = 2'd1,
    ST_DATA  = 2'd2,
    ST_TAIL  = 2'd3
  } seq_st_e;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_FLAG = 2'd1,
    CMD_DATA = 2'd2,
    CMD_ZERO = 2'd3
  } byte_cmd_e;

  localparam int unsigned FLAG_DIV = 800;
  localparam int unsigned CAL_SHIFT = 3;
endpackage

// File: rtl/ptt_seq_cfg.sv
module ptt_seq_cfg #(
  parameter int unsigned P_W         = 8,
  parameter int unsigned BR_W        = 21,
  parameter int unsigned DEF_TXD     = 20,
  parameter int unsigned DEF_TAIL    = 2,
  parameter int unsigned DEF_SLOT    = 10,
  parameter int unsigned DEF_PERSIST = 40,
  parameter bit          DEF_FULL    = 1'b0,
  parameter int unsigned DEF_BITRATE = 9600
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [P_W-1:0]  txd_i,
  input  logic [P_W-1:0]  tail_i,
  input  logic [P_W-1:0]  slot_i,
  input  logic [P_W-1:0]  persist_i,
  input  logic            full_i,
  input  logic [BR_W-1:0] bitrate_i,
  output logic [P_W-1:0]  txd_o,
  output logic [P_W-1:0]  tail_o,
  output logic [P_W-1:0]  slot_o,
  output logic [P_W-1:0]  persist_o,
  output logic            full_o,
  output logic [BR_W-1:0] bitrate_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txd_o     <= P_W'(DEF_TXD);
      tail_o    <= P_W'(DEF_TAIL);
      slot_o    <= P_W'(DEF_SLOT);
      persist_o <= P_W'(DEF_PERSIST);
      full_o    <= DEF_FULL;
      bitrate_o <= BR_W'(DEF_BITRATE);
    end else if (wr_i) begin
      txd_o     <= txd_i;
      tail_o    <= tail_i;
      slot_o    <= slot_i;
      persist_o <= persist_i;
      full_o    <= full_i;
      bitrate_o <= bitrate_i;
    end
  end
endmodule

// File: rtl/ptt_seq_len.sv
module ptt_seq_len
  import ptt_seq_pkg::*;
#(
  parameter int unsigned P_W   = 8,
  parameter int unsigned BR_W  = 21,
  parameter int unsigned SEC_W = 8,
  parameter int unsigned CNT_W = 20,
  parameter int unsigned CAL_W = 28
) (
  input  logic [P_W-1:0]   txd_i,
  input  logic [P_W-1:0]   tail_i,
  input  logic [BR_W-1:0]  bitrate_i,
  input  logic [SEC_W-1:0] secs_i,
  output logic [CNT_W-1:0] keyup_len_o,
  output logic [CNT_W-1:0] tail_len_o,
  output logic [CAL_W-1:0] cal_len_o
);
  localparam int unsigned FP_W = P_W + BR_W;
  localparam int unsigned CP_W = SEC_W + BR_W;

  logic [FP_W-1:0] keyup_prod, tail_prod;
  logic [CP_W-1:0] cal_prod;

  assign keyup_prod  = FP_W'(txd_i) * FP_W'(bitrate_i);
  assign tail_prod   = FP_W'(tail_i) * FP_W'(bitrate_i);
  assign cal_prod    = CP_W'(secs_i) * CP_W'(bitrate_i);
  // flag bytes = units of 10 ms * bit/s / 800
  assign keyup_len_o = CNT_W'(keyup_prod / FP_W'(FLAG_DIV));
  assign tail_len_o  = CNT_W'(tail_prod / FP_W'(FLAG_DIV));
  assign cal_len_o   = CAL_W'(cal_prod >> CAL_SHIFT);
endmodule

// File: rtl/ptt_seq_access.sv
module ptt_seq_access #(
  parameter int unsigned P_W      = 8,
  parameter int unsigned DEF_SLOT = 10
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           eval_i,
  input  logic           cfg_wr_i,
  input  logic           dcd_i,
  input  logic [7:0]     rnd_i,
  input  logic [P_W-1:0] slot_time_i,
  input  logic [P_W-1:0] persist_i,
  input  logic           full_dup_i,
  output logic           grant_o
);
  logic [P_W-1:0] slot_q, slot_d;

  always_comb begin
    grant_o = 1'b0;
    slot_d  = slot_q;
    if (eval_i) begin
      if (full_dup_i) begin
        grant_o = 1'b1;
      end else if (dcd_i) begin
        slot_d = slot_time_i;
      end else if (slot_q > P_W'(1)) begin
        slot_d = slot_q - P_W'(1);
      end else begin
        slot_d  = slot_time_i;
        grant_o = ({{(P_W > 8 ? P_W - 8 : 0){1'b0}}, rnd_i} <= persist_i);
      end
    end
    if (cfg_wr_i) slot_d = P_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= P_W'(DEF_SLOT);
    else         slot_q <= slot_d;
  end

  AST_CARRIER_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && dcd_i && !full_dup_i && !cfg_wr_i) |=> (slot_q == $past(slot_time_i))); // R2
  AST_COUNTDOWN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && !dcd_i && !full_dup_i && slot_q > P_W'(1)) |-> !grant_o); // R3
  AST_PERSIST_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && !full_dup_i) |-> ({{(P_W > 8 ? P_W - 8 : 0){1'b0}}, rnd_i} <= persist_i)); // R4
  AST_CFG_SLOT_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i |=> (slot_q == P_W'(1))); // R11
endmodule

// File: rtl/ptt_seq.sv
module ptt_seq
  import ptt_seq_pkg::*;
#(
  parameter int unsigned P_W         = 8,
  parameter int unsigned BR_W        = 21,
  parameter int unsigned SEC_W       = 8,
  parameter int unsigned CNT_W       = 20,
  parameter int unsigned CAL_W       = 28,
  parameter int unsigned KEYUP_W     = 16,
  parameter int unsigned DEF_SLOT    = 10,
  parameter int unsigned DEF_BITRATE = 9600
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               byte_req_i,
  input  logic               dcd_i,
  input  logic               frame_avail_i,
  input  logic               ptt_fb_i,
  input  logic [7:0]         rnd_i,
  input  logic               cfg_wr_i,
  input  logic [P_W-1:0]     cfg_txd_i,
  input  logic [P_W-1:0]     cfg_tail_i,
  input  logic [P_W-1:0]     cfg_slot_i,
  input  logic [P_W-1:0]     cfg_persist_i,
  input  logic               cfg_full_i,
  input  logic [BR_W-1:0]    cfg_bitrate_i,
  input  logic               cal_start_i,
  input  logic [SEC_W-1:0]   cal_secs_i,
  output logic [1:0]         cmd_o,
  output logic               key_o,
  output logic [KEYUP_W-1:0] keyups_o
);
  logic [P_W-1:0]  txd, tail, slot_time, persist;
  logic            full_dup;
  logic [BR_W-1:0] bitrate;
  logic [CNT_W-1:0] keyup_len, tail_len;
  logic [CAL_W-1:0] cal_len;
  logic            eval, grant;

  seq_st_e          st_q, st_d;
  byte_cmd_e        cmd;
  logic [CNT_W-1:0] flag_q, flag_d;
  logic [CAL_W-1:0] cal_q, cal_d;
  logic [KEYUP_W-1:0] keyups_q, keyups_d;

  ptt_seq_cfg #(
    .P_W(P_W), .BR_W(BR_W), .DEF_TXD(20), .DEF_TAIL(2), .DEF_SLOT(DEF_SLOT),
    .DEF_PERSIST(40), .DEF_FULL(1'b0), .DEF_BITRATE(DEF_BITRATE)
  ) u_cfg (
    .clk_i, .rst_ni, .wr_i(cfg_wr_i),
    .txd_i(cfg_txd_i), .tail_i(cfg_tail_i), .slot_i(cfg_slot_i),
    .persist_i(cfg_persist_i), .full_i(cfg_full_i), .bitrate_i(cfg_bitrate_i),
    .txd_o(txd), .tail_o(tail), .slot_o(slot_time), .persist_o(persist),
    .full_o(full_dup), .bitrate_o(bitrate)
  );

  ptt_seq_len #(
    .P_W(P_W), .BR_W(BR_W), .SEC_W(SEC_W), .CNT_W(CNT_W), .CAL_W(CAL_W)
  ) u_len (
    .txd_i(txd), .tail_i(tail), .bitrate_i(bitrate), .secs_i(cal_secs_i),
    .keyup_len_o(keyup_len), .tail_len_o(tail_len), .cal_len_o(cal_len)
  );

  // contend only when idle, a frame waits and no calibration is pending
  assign eval = tick_i && (st_q == ST_IDLE) && frame_avail_i && (cal_q == '0);

  ptt_seq_access #(.P_W(P_W), .DEF_SLOT(DEF_SLOT)) u_access (
    .clk_i, .rst_ni, .eval_i(eval), .cfg_wr_i,
    .dcd_i, .rnd_i, .slot_time_i(slot_time), .persist_i(persist),
    .full_dup_i(full_dup), .grant_o(grant)
  );

  always_comb begin
    st_d     = st_q;
    flag_d   = flag_q;
    cal_d    = cal_q;
    keyups_d = keyups_q;
    cmd      = CMD_NONE;
    unique case (st_q)
      ST_IDLE: begin
        if (byte_req_i && cal_q != '0) begin
          cmd   = CMD_ZERO;
          cal_d = cal_q - CAL_W'(1);
        end
        if (grant) begin
          st_d     = ST_KEYUP;
          flag_d   = keyup_len;
          keyups_d = keyups_q + KEYUP_W'(1);
        end
      end
      ST_KEYUP: begin
        if (byte_req_i) begin
          if (flag_q == '0) begin
            st_d = ST_DATA;
          end else begin
            cmd    = CMD_FLAG;
            flag_d = flag_q - CNT_W'(1);
            if (flag_q == CNT_W'(1)) st_d = ST_DATA;
          end
        end
      end
      ST_DATA: begin
        if (byte_req_i) begin
          if (frame_avail_i) begin
            cmd = CMD_DATA;
          end else begin
            st_d   = ST_TAIL;
            flag_d = tail_len;
          end
        end
      end
      ST_TAIL: begin
        if (!ptt_fb_i) begin
          st_d = ST_IDLE;
        end else if (byte_req_i) begin
          if (frame_avail_i) begin
            st_d = ST_DATA;
          end else if (flag_q != '0) begin
            cmd    = CMD_FLAG;
            flag_d = flag_q - CNT_W'(1);
          end else if (cal_q != '0) begin
            cmd   = CMD_ZERO;
            cal_d = cal_q - CAL_W'(1);
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (cal_start_i) cal_d = cal_len;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      flag_q   <= '0;
      cal_q    <= '0;
      keyups_q <= '0;
    end else begin
      st_q     <= st_d;
      flag_q   <= flag_d;
      cal_q    <= cal_d;
      keyups_q <= keyups_d;
    end
  end

  assign cmd_o    = cmd;
  assign key_o    = (st_q != ST_IDLE);
  assign keyups_o = keyups_q;

  AST_FLAG_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_KEYUP && cmd == CMD_FLAG) |=> (flag_q == $past(flag_q) - CNT_W'(1))); // R6
  AST_CMD_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o != 2'd0) |-> byte_req_i); // R7
  AST_TAIL_EXIT_FB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TAIL && st_d == ST_IDLE) |-> !ptt_fb_i); // R8
  AST_ZERO_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_ZERO) |-> (st_q == ST_IDLE || (st_q == ST_TAIL && flag_q == '0))); // R9
  AST_CAL_BLOCKS_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && cal_q != '0) |=> (st_q == ST_IDLE)); // R9
  AST_KEYUP_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && st_d == ST_KEYUP) |=> (keyups_q == $past(keyups_q) + KEYUP_W'(1))); // R10
endmodule

// File: tb/ptt_seq_bench.sv
module ptt_seq_bench;
  localparam int unsigned BR_W = 21;
  localparam int unsigned KW   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, req = 0, dcd = 0, favail = 0, ptt_fb = 1;
  logic [7:0] rnd = 0;
  logic cfg_wr = 0, cfg_full = 0, cal_start = 0;
  logic [7:0] cfg_txd = 20, cfg_tail = 2, cfg_slot = 3, cfg_persist = 40, cal_secs = 0;
  logic [BR_W-1:0] cfg_bitrate = 1200;
  logic [1:0] cmd;
  logic key;
  logic [KW-1:0] keyups;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ptt_seq #(.DEF_SLOT(3), .DEF_BITRATE(1200)) u_ptt_seq (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .byte_req_i(req), .dcd_i(dcd),
    .frame_avail_i(favail), .ptt_fb_i(ptt_fb), .rnd_i(rnd), .cfg_wr_i(cfg_wr),
    .cfg_txd_i(cfg_txd), .cfg_tail_i(cfg_tail), .cfg_slot_i(cfg_slot),
    .cfg_persist_i(cfg_persist), .cfg_full_i(cfg_full), .cfg_bitrate_i(cfg_bitrate),
    .cal_start_i(cal_start), .cal_secs_i(cal_secs),
    .cmd_o(cmd), .key_o(key), .keyups_o(keyups)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, sample command before the edge
  task automatic step(input logic t, input logic r, output logic [1:0] c);
    @(negedge clk);
    tick = t; req = r;
    #1 c = cmd;
    @(posedge clk);
    #1;
    tick = 0; req = 0; cfg_wr = 0; cal_start = 0;
  endtask

  task automatic cfg_write(input int txd, input int slot, input int pers,
                           input logic full, input int br);
    logic [1:0] c;
    cfg_txd = 8'(txd); cfg_tail = 8'd2; cfg_slot = 8'(slot);
    cfg_persist = 8'(pers); cfg_full = full; cfg_bitrate = BR_W'(br);
    @(negedge clk); cfg_wr = 1;
    step(0, 0, c);
  endtask

  task automatic count_cmd(input logic [1:0] want, output int n, output logic [1:0] last);
    logic [1:0] c;
    n = 0; last = 0;
    for (int i = 0; i < 400; i++) begin
      step(0, 1, c);
      if (c == want) n++;
      else begin last = c; break; end
    end
  endtask

  task automatic go_idle();
    logic [1:0] c;
    favail = 0;
    repeat (60) step(0, 1, c);
    ptt_fb = 0;
    step(0, 0, c);
    ptt_fb = 1;
  endtask

  task automatic t_reset_access();
    logic [1:0] c;
    #1;
    chk("R1 key", int'(key), 0);
    chk("R1 cmd", int'(cmd), 0);
    chk("R1 keyups", int'(keyups), 0);
    favail = 1; dcd = 0; rnd = 0;
    step(1, 0, c); chk("R3 countdown 3->2", int'(key), 0);
    step(1, 0, c); chk("R3 countdown 2->1", int'(key), 0);
    rnd = 41;
    step(1, 0, c); chk("R4 rnd above default persist", int'(key), 0);
    rnd = 0;
    step(1, 0, c); chk("R3 reload after fail", int'(key), 0);
    step(1, 0, c); chk("R3 reload after fail 2", int'(key), 0);
    rnd = 40;
    step(1, 0, c); chk("R4 R12 rnd equal persist keys", int'(key), 1);
    chk("R10 first keyup", int'(keyups), 1);
  endtask

  task automatic t_frame_flow();
    int n; logic [1:0] last; logic [1:0] c;
    count_cmd(2'd1, n, last);
    chk("R6 R12 preamble flags", n, 30);
    chk("R7 first data", int'(last), 2);
    for (int i = 0; i < 4; i++) begin
      step(0, 1, c); chk("R7 data byte", int'(c), 2);
    end
    step(0, 0, c); chk("R7 no cmd without req", int'(c), 0);
    favail = 0;
    step(0, 1, c); chk("R7 end of frame no cmd", int'(c), 0);
    count_cmd(2'd1, n, last);
    chk("R7 R12 tail flags", n, 3);
    chk("R8 tail idle cmd", int'(last), 0);
    chk("R8 keyed while fb high", int'(key), 1);
    favail = 1;
    step(0, 1, c); chk("R8 tail to data no cmd", int'(c), 0);
    step(0, 1, c); chk("R8 data resumes", int'(c), 2);
    favail = 0;
    step(0, 1, c);
    count_cmd(2'd1, n, last);
    chk("R8 second tail", n, 3);
    ptt_fb = 0;
    step(0, 0, c);
    chk("R8 idle after fb drop", int'(key), 0);
    ptt_fb = 1;
  endtask

  task automatic t_carrier_cfg();
    logic [1:0] c;
    cfg_write(20, 3, 255, 0, 1200);
    favail = 1; dcd = 1; rnd = 0;
    step(1, 0, c); chk("R2 busy defers", int'(key), 0);
    dcd = 0;
    step(1, 0, c); chk("R2 reloaded 3->2", int'(key), 0);
    step(1, 0, c); chk("R2 reloaded 2->1", int'(key), 0);
    step(1, 0, c); chk("R2 keys after slot", int'(key), 1);
    go_idle();
    cfg_write(20, 3, 255, 0, 1200);
    favail = 1;
    step(1, 0, c); chk("R11 cfg write forces immediate test", int'(key), 1);
    chk("R10 keyups", int'(keyups), 3);
    go_idle();
  endtask

  task automatic t_full_dup();
    logic [1:0] c;
    cfg_write(20, 3, 0, 1, 1200);
    favail = 1; dcd = 1; rnd = 8'hff;
    step(1, 0, c); chk("R5 full duplex keys at once", int'(key), 1);
    go_idle();
    dcd = 0;
  endtask

  task automatic t_lengths();
    int n; logic [1:0] last; logic [1:0] c;
    cfg_write(0, 3, 0, 1, 1200);
    favail = 1;
    step(1, 0, c);
    step(0, 1, c); chk("R6 empty preamble no cmd", int'(c), 0);
    step(0, 1, c); chk("R6 empty preamble data", int'(c), 2);
    go_idle();
    cfg_write(20, 3, 0, 1, 1000);
    favail = 1;
    step(1, 0, c);
    count_cmd(2'd1, n, last); chk("R6 preamble at 1000", n, 25);
    go_idle();
    cfg_write(7, 3, 0, 1, 1200);
    favail = 1;
    step(1, 0, c);
    count_cmd(2'd1, n, last); chk("R6 preamble floor", n, 10);
    go_idle();
  endtask

  task automatic t_calibration();
    int n; logic [1:0] last; logic [1:0] c;
    cfg_write(20, 3, 0, 1, 1200);
    favail = 0; cal_secs = 1;
    @(negedge clk); cal_start = 1;
    step(0, 0, c);
    favail = 1;
    step(1, 1, c);
    chk("R9 zero byte", int'(c), 3);
    chk("R9 no keyup during calibration", int'(key), 0);
    count_cmd(2'd3, n, last);
    chk("R9 zero count", n + 1, 150);
    chk("R9 end of zeros", int'(last), 0);
    step(1, 0, c); chk("R9 keys after calibration", int'(key), 1);
    chk("R10 keyups total", int'(keyups), 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset_access();
    t_frame_flow();
    t_carrier_cfg();
    t_full_dup();
    t_lengths();
    t_calibration();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule